// File: doc/BRIEF.md
# Register-Mapped SPI Master with Byte FIFOs

This block is a memory-mapped SPI master. Software talks to it through a small 32-bit register bus. It writes bytes into a transmit FIFO and reads received bytes from a receive FIFO. It picks the clock polarity, clock phase and bit order in a control register, and drives the slave selects from a register that it writes directly.

The serial engine shifts 8-bit frames. It derives the serial clock from the system clock through a parameterised divider. While a hold bit in the control register is set, no clocking takes place. Software can therefore queue a whole burst first and then release it, and the queued bytes go out back to back. A loopback option feeds the outgoing serial data straight into the receive shifter. Writing a fixed key to the reset register returns the whole block to its reset state.

Register offsets on the byte-addressed bus: 0x40 reset key, 0x60 control, 0x64 status, 0x68 transmit data, 0x6C receive data, 0x70 slave select, 0x74 transmit occupancy, 0x78 receive occupancy. Any other offset reads zero.

Top module: `spim_top`

## Requirements
- R1: After reset the registers read as follows: control reads 0x180, status reads 0x25, slave select reads all ones, and both occupancy registers read 0. The serial clock rests at 0.
- R2: Control bits are: 0 loopback, 1 enable, 2 master, 3 CPOL, 4 CPHA, 5 transmit-FIFO flush, 6 receive-FIFO flush, 7 manual select, 8 hold, 9 LSB first. Status bits are: 0 receive empty, 1 receive full, 2 transmit empty, 3 transmit full, 4 mode fault (always 0), 5 slave-mode select (always 1).
- R3: In all four clock modes the serial clock idles at CPOL. With CPHA=0 the data is sampled on the leading edge of each bit. With CPHA=1 it is sampled on the trailing edge. Each frame has exactly 16 clock edges.
- R4: With control bit 9 at 0, bit 7 of each byte is sent first and arrives first. With bit 9 at 1, bit 0 is sent first and arrives first.
- R5: While the hold bit (8) is 1, or enable or master is 0, no frame starts, even if the transmit FIFO holds data.
- R6: Once the hold is cleared, queued bytes are sent back to back. Status bit 2 reads 1 only when the FIFO is empty and the last byte has been fully shifted out.
- R7: Each received frame enters the receive FIFO in order. A read of offset 0x6C returns the oldest byte in bits 7:0 and removes it.
- R8: The slave-select outputs are active low and equal the value last written at 0x70, which also reads back.
- R9: A write to a full transmit FIFO is dropped. Transmit occupancy reads the entry count minus one (0 when empty), so a full 16-entry FIFO reads 15.
- R10: A frame that arrives while the receive FIFO is full is discarded. The older entries are kept.
- R11: Writing control with bit 5 or bit 6 set empties the transmit or receive FIFO. Both bits always read back as 0.
- R12: Writing 0x0000000A to offset 0x40 restores the R1 state. Any other value written there changes nothing.
- R13: In loopback mode the receive shifter takes the outgoing data, and the external MISO pin is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid combinationally during a read |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | NUM_SS | Active-low slave selects |

## Verification
Single frames are run in each of the four clock modes, with an external slave model that uses distinct transmit and reply bytes. A wrong sampling edge or a wrong idle level then corrupts one direction or the other. The LSB-first cases use asymmetric bytes such as 0x01 against 0x80, so a reversed bit order cannot pass. The loopback cases reply with a byte that differs from the one sent, so a receive path that still listens to MISO is caught. A held three-byte burst shows that the hold stops all clocking, counts 48 edges once released, and reads transmit-empty as 0 while the final byte is still shifting. A seventeen-byte fill followed by an extra frame shows which entry is dropped at each FIFO boundary.

// File: rtl/spim_pkg.sv
`timescale 1ns/1ps
package spim_pkg;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_SRST  = 8'h40;
  localparam logic [ADDR_W-1:0] OFS_CTRL  = 8'h60;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 8'h64;
  localparam logic [ADDR_W-1:0] OFS_TXD   = 8'h68;
  localparam logic [ADDR_W-1:0] OFS_RXD   = 8'h6C;
  localparam logic [ADDR_W-1:0] OFS_SSEL  = 8'h70;
  localparam logic [ADDR_W-1:0] OFS_TXOCC = 8'h74;
  localparam logic [ADDR_W-1:0] OFS_RXOCC = 8'h78;

  localparam logic [31:0] SRST_KEY = 32'h0000_000A;

  localparam int C_LOOP  = 0;
  localparam int C_EN    = 1;
  localparam int C_MSTR  = 2;
  localparam int C_CPOL  = 3;
  localparam int C_CPHA  = 4;
  localparam int C_TXRST = 5;
  localparam int C_RXRST = 6;
  localparam int C_MANSS = 7;
  localparam int C_HOLD  = 8;
  localparam int C_LSB   = 9;
  localparam int CTRL_W  = 10;
  localparam logic [CTRL_W-1:0] CTRL_RST = 10'h180;

  typedef struct packed {
    logic lsb;
    logic cpha;
    logic cpol;
    logic loop;
  } spim_mode_t;
endpackage

// File: rtl/spim_fifo.sv
`timescale 1ns/1ps
module spim_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8,
  parameter int REQ_TAG = 9,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata,
  output logic [CW-1:0]    count,
  output logic             full,
  output logic             empty
);
  localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CNT_MAX  = CW'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wr_q, wr_n, rd_q, rd_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic do_push, do_pop;

  always_comb begin
    full    = (cnt_q == CNT_MAX);
    empty   = (cnt_q == '0);
    do_push = push && !full;
    do_pop  = pop && !empty;
    wr_n    = wr_q;
    rd_n    = rd_q;
    if (do_push) wr_n = (wr_q == PTR_LAST) ? '0 : wr_q + 1'b1;
    if (do_pop)  rd_n = (rd_q == PTR_LAST) ? '0 : rd_q + 1'b1;
    cnt_n = cnt_q + CW'(do_push) - CW'(do_pop);
    if (clr) begin
      wr_n  = '0;
      rd_n  = '0;
      cnt_n = '0;
    end
    rdata = mem[rd_q];
    count = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_n;
      rd_q  <= rd_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !clr) mem[wr_q] <= wdata;
  end

  // R9 / R10: occupancy never passes the depth
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_MAX)
    else $error("fifo (req %0d) count above depth", REQ_TAG);

  // R9 / R10: a push into a full FIFO without a pop leaves it full, unchanged
  assert_full_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !clr) |=> (cnt_q == CNT_MAX) && $stable(wr_q))
    else $error("fifo (req %0d) accepted a push while full", REQ_TAG);
endmodule

// File: rtl/spim_engine.sv
`timescale 1ns/1ps
module spim_engine
  import spim_pkg::*;
#(
  parameter int CLK_DIV = 2,
  localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       go,
  input  spim_mode_t mode,
  input  logic       tx_avail,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       tx_pop,
  output logic       rx_push,
  output logic [7:0] rx_byte,
  output logic       busy,
  output logic       sclk,
  output logic       mosi
);
  localparam logic [DW-1:0] DIV_LAST = DW'(CLK_DIV - 1);

  logic          busy_q, busy_n, sclk_q, sclk_n;
  logic [DW-1:0] div_q, div_n;
  logic [3:0]    edge_q, edge_n;
  logic [7:0]    tsh_q, tsh_n, rsh_q, rsh_n;
  logic          tick, lead, last, smp, shf, in_bit, out_bit;

  always_comb begin
    tick    = busy_q && (div_q == DIV_LAST);
    lead    = ~edge_q[0];
    last    = (edge_q == 4'hF);
    smp     = tick && (lead ^ mode.cpha);
    shf     = tick && !(lead ^ mode.cpha) && !last && !(mode.cpha && edge_q == 4'h0);
    out_bit = mode.lsb ? tsh_q[0] : tsh_q[7];
    in_bit  = mode.loop ? out_bit : miso;

    rsh_n = rsh_q;
    if (smp) rsh_n = mode.lsb ? {in_bit, rsh_q[7:1]} : {rsh_q[6:0], in_bit};
    tsh_n = tsh_q;
    if (shf) tsh_n = mode.lsb ? {1'b0, tsh_q[7:1]} : {tsh_q[6:0], 1'b0};

    busy_n  = busy_q;
    sclk_n  = busy_q ? (tick ? ~sclk_q : sclk_q) : mode.cpol;
    div_n   = (busy_q && !tick) ? div_q + 1'b1 : '0;
    edge_n  = tick ? edge_q + 1'b1 : edge_q;
    tx_pop  = 1'b0;
    rx_push = 1'b0;
    rx_byte = rsh_n;

    if (!busy_q) begin
      if (go && tx_avail) begin
        busy_n = 1'b1;
        tsh_n  = tx_byte;
        tx_pop = 1'b1;
        edge_n = 4'h0;
      end
    end else if (tick && last) begin
      rx_push = 1'b1;
      if (go && tx_avail) begin
        tsh_n  = tx_byte;
        tx_pop = 1'b1;
      end else begin
        busy_n = 1'b0;
      end
    end

    busy = busy_q;
    sclk = sclk_q;
    mosi = out_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sclk_q <= 1'b0;
      div_q  <= '0;
      edge_q <= 4'h0;
      tsh_q  <= 8'h00;
      rsh_q  <= 8'h00;
    end else if (clr) begin
      busy_q <= 1'b0;
      sclk_q <= 1'b0;
      div_q  <= '0;
      edge_q <= 4'h0;
      tsh_q  <= 8'h00;
      rsh_q  <= 8'h00;
    end else begin
      busy_q <= busy_n;
      sclk_q <= sclk_n;
      div_q  <= div_n;
      edge_q <= edge_n;
      tsh_q  <= tsh_n;
      rsh_q  <= rsh_n;
    end
  end

  // R3: between frames the clock rests at the selected polarity
  assert_idle_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !$past(busy_q) && $stable(mode.cpol) && !$past(clr)) |-> (sclk_q == mode.cpol))
    else $error("serial clock not at idle level");
endmodule

// File: rtl/spim_top.sv
`timescale 1ns/1ps
module spim_top
  import spim_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int CLK_DIV    = 2,
  parameter int NUM_SS     = 4,
  localparam int CW = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [NUM_SS-1:0] ss_n
);
  logic [CTRL_W-1:0] ctrl_q, ctrl_n;
  logic [NUM_SS-1:0] ss_q, ss_n_d;
  logic wr, rd, srst, ctrl_wr, tx_clr, rx_clr, go;
  logic tx_push, tx_pop, tx_full, tx_empty, rx_push, rx_pop, rx_full, rx_empty, eng_busy;
  logic [7:0] tx_head, rx_head, rx_byte;
  logic [CW-1:0] tx_cnt, rx_cnt;
  spim_mode_t mode;

  function automatic logic [31:0] occ(input logic [CW-1:0] c);
    return (c == '0) ? 32'd0 : 32'(c) - 32'd1;
  endfunction

  always_comb begin
    wr      = bus_sel && bus_we;
    rd      = bus_sel && !bus_we;
    srst    = wr && (bus_addr == OFS_SRST) && (bus_wdata == SRST_KEY);
    ctrl_wr = wr && (bus_addr == OFS_CTRL);
    tx_clr  = srst || (ctrl_wr && bus_wdata[C_TXRST]);
    rx_clr  = srst || (ctrl_wr && bus_wdata[C_RXRST]);
    tx_push = wr && (bus_addr == OFS_TXD);
    rx_pop  = rd && (bus_addr == OFS_RXD);

    ctrl_n = ctrl_q;
    if (srst) ctrl_n = CTRL_RST;
    else if (ctrl_wr) begin
      ctrl_n = bus_wdata[CTRL_W-1:0];
      ctrl_n[C_TXRST] = 1'b0;
      ctrl_n[C_RXRST] = 1'b0;
    end
    ss_n_d = ss_q;
    if (srst) ss_n_d = '1;
    else if (wr && bus_addr == OFS_SSEL) ss_n_d = bus_wdata[NUM_SS-1:0];

    go   = ctrl_q[C_EN] && ctrl_q[C_MSTR] && !ctrl_q[C_HOLD];
    mode = '{lsb: ctrl_q[C_LSB], cpha: ctrl_q[C_CPHA], cpol: ctrl_q[C_CPOL], loop: ctrl_q[C_LOOP]};

    unique case (bus_addr)
      OFS_CTRL:  bus_rdata = 32'(ctrl_q);
      OFS_STAT:  bus_rdata = {26'd0, 1'b1, 1'b0, tx_full, tx_empty && !eng_busy, rx_full, rx_empty};
      OFS_RXD:   bus_rdata = {24'd0, rx_head};
      OFS_SSEL:  bus_rdata = 32'(ss_q);
      OFS_TXOCC: bus_rdata = occ(tx_cnt);
      OFS_RXOCC: bus_rdata = occ(rx_cnt);
      default:   bus_rdata = 32'd0;
    endcase
    ss_n = ss_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
      ss_q   <= '1;
    end else begin
      ctrl_q <= ctrl_n;
      ss_q   <= ss_n_d;
    end
  end

  spim_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8), .REQ_TAG(9)) u_txf (
    .clk(clk), .rst_n(rst_n), .clr(tx_clr), .push(tx_push), .pop(tx_pop),
    .wdata(bus_wdata[7:0]), .rdata(tx_head), .count(tx_cnt), .full(tx_full), .empty(tx_empty));

  spim_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8), .REQ_TAG(10)) u_rxf (
    .clk(clk), .rst_n(rst_n), .clr(rx_clr), .push(rx_push), .pop(rx_pop),
    .wdata(rx_byte), .rdata(rx_head), .count(rx_cnt), .full(rx_full), .empty(rx_empty));

  spim_engine #(.CLK_DIV(CLK_DIV)) u_eng (
    .clk(clk), .rst_n(rst_n), .clr(srst), .go(go), .mode(mode),
    .tx_avail(!tx_empty), .tx_byte(tx_head), .miso(miso),
    .tx_pop(tx_pop), .rx_push(rx_push), .rx_byte(rx_byte),
    .busy(eng_busy), .sclk(sclk), .mosi(mosi));

  // R5: while held, an idle engine stays idle
  assert_hold_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[C_HOLD] && !eng_busy) |=> !eng_busy)
    else $error("frame started while held");

  // R12: the key write restores control and select registers
  assert_key_reset_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == OFS_SRST && bus_wdata == SRST_KEY) |=> (ctrl_q == CTRL_RST) && (ss_q == '1))
    else $error("key write did not reset registers");

  // R12: any other value at the reset offset leaves control untouched
  assert_bad_key_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == OFS_SRST && bus_wdata != SRST_KEY) |=> $stable(ctrl_q))
    else $error("non-key write changed control");
endmodule

// File: tb/spim_top_tb.sv
`timescale 1ns/1ps
module spim_top_tb;
  localparam int NSS = 4;
  logic clk, rst_n, bus_sel, bus_we, miso;
  logic [7:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic sclk, mosi;
  logic [NSS-1:0] ss_n;

  int checks = 0, fails = 0;
  logic m_cpol = 0, m_cpha = 0, m_lsb = 0, sl_on = 0, cnt_on = 0;
  logic [7:0] s_tx = 0, s_rx = 0;
  int k = 0, sclk_edges = 0;

  spim_top u_dut (.clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n));

  initial clk = 0;
  always #4 clk = ~clk;

  // {lsb,cpha,cpol,loop}, byte sent, slave reply
  localparam logic [19:0] VEC [8] = '{
    {4'b0000, 8'hA5, 8'h3C}, {4'b0100, 8'h96, 8'hC3},
    {4'b0010, 8'h81, 8'h7E}, {4'b0110, 8'h5A, 8'hE1},
    {4'b1000, 8'h01, 8'h80}, {4'b1110, 8'h3B, 8'hD2},
    {4'b0101, 8'hC7, 8'h00}, {4'b1011, 8'h2E, 8'hFF}};

  function automatic int bix(int kk);
    return m_lsb ? (kk & 7) : 7 - (kk & 7);
  endfunction

  always @(sclk) begin
    if (sl_on) begin
      if (!m_cpha) begin
        if (sclk != m_cpol) s_rx[bix(k)] = mosi;
        else begin k = k + 1; miso = s_tx[bix(k)]; end
      end else begin
        if (sclk != m_cpol) miso = s_tx[bix(k)];
        else begin s_rx[bix(k)] = mosi; k = k + 1; end
      end
    end
    if (cnt_on) sclk_edges = sclk_edges + 1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); #1;
    bus_sel = 0;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 3000; i++) begin
      bus_rd(8'h64, s);
      if (s[2]) break;
    end
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL R6: watchdog expired, actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic [31:0] cv;
    bus_sel = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0; miso = 0;
    rst_n = 0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    bus_rd(8'h60, r); check("R1 control", r, 32'h180);
    bus_rd(8'h64, r); check("R1 status", r, 32'h25);
    bus_rd(8'h70, r); check("R1 select", r, 32'hF);
    bus_rd(8'h74, r); check("R1 tx occupancy", r, 0);
    check("R1 sclk idle", {31'd0, sclk}, 0);

    // table of single frames: R3 R4 R13 R7 R8
    for (int v = 0; v < 8; v++) begin
      m_lsb = VEC[v][19]; m_cpha = VEC[v][18]; m_cpol = VEC[v][17];
      cv = 32'h086 | (32'(VEC[v][19]) << 9) | (32'(VEC[v][18]) << 4) |
           (32'(VEC[v][17]) << 3) | 32'(VEC[v][16]);
      bus_wr(8'h60, cv | 32'h100);
      repeat (3) @(posedge clk);
      s_tx = VEC[v][7:0]; s_rx = 0; k = 0; miso = s_tx[bix(0)];
      sl_on = 1;
      bus_wr(8'h70, 32'hE);
      bus_wr(8'h68, 32'(VEC[v][15:8]));
      bus_wr(8'h60, cv);
      wait_idle();
      check("R3 idle level after frame", {31'd0, sclk}, {31'd0, m_cpol});
      check("R8 select held", 32'(ss_n), 32'hE);
      bus_rd(8'h6C, r);
      if (VEC[v][16]) check("R13 loopback receives sent byte", r, 32'(VEC[v][15:8]));
      else begin
        check("R3 R4 master receives reply", r, 32'(VEC[v][7:0]));
        check("R3 R4 slave receives sent byte", 32'(s_rx), 32'(VEC[v][15:8]));
      end
      sl_on = 0;
      bus_wr(8'h70, 32'hF);
    end

    // R5 hold and R6 burst
    m_cpol = 0;
    bus_wr(8'h60, 32'h187);
    repeat (2) @(posedge clk);
    sclk_edges = 0; cnt_on = 1;
    bus_wr(8'h68, 32'h11); bus_wr(8'h68, 32'h22); bus_wr(8'h68, 32'h33);
    repeat (64) @(posedge clk);
    check("R5 no clocking while held", sclk_edges, 0);
    bus_rd(8'h64, r); check("R5 tx not empty while held", {31'd0, r[2]}, 0);
    bus_rd(8'h74, r); check("R9 tx occupancy 3 entries", r, 2);
    bus_wr(8'h60, 32'h087);
    repeat (78) @(posedge clk);
    bus_rd(8'h64, r); check("R6 tx empty low during last byte", {31'd0, r[2]}, 0);
    wait_idle();
    check("R6 burst edge count", sclk_edges, 48);
    cnt_on = 0;
    bus_rd(8'h78, r); check("R7 rx occupancy", r, 2);
    bus_rd(8'h6C, r); check("R7 first byte", r, 32'h11);
    bus_rd(8'h6C, r); check("R7 second byte", r, 32'h22);
    bus_rd(8'h6C, r); check("R7 third byte", r, 32'h33);
    bus_rd(8'h64, r); check("R7 rx empty after reads", {31'd0, r[0]}, 1);

    // R9 full and R11 flush
    bus_wr(8'h60, 32'h187);
    for (int i = 0; i < 17; i++) bus_wr(8'h68, 32'h40 + 32'(i));
    bus_rd(8'h64, r); check("R9 tx full flag", {31'd0, r[3]}, 1);
    bus_rd(8'h74, r); check("R9 tx occupancy full", r, 15);
    bus_wr(8'h60, 32'h1A7);
    bus_rd(8'h64, r); check("R11 tx flushed", {31'd0, r[2]}, 1);
    bus_rd(8'h60, r); check("R11 flush bit reads 0", r, 32'h187);

    // R9 drop and R10 discard
    for (int i = 0; i < 16; i++) bus_wr(8'h68, 32'h40 + 32'(i));
    bus_wr(8'h68, 32'hEE);
    bus_wr(8'h60, 32'h087);
    wait_idle();
    bus_rd(8'h64, r); check("R10 rx full flag", {31'd0, r[1]}, 1);
    bus_wr(8'h68, 32'h99);
    wait_idle();
    bus_rd(8'h78, r); check("R10 rx occupancy stays full", r, 15);
    for (int i = 0; i < 16; i++) begin
      bus_rd(8'h6C, r);
      check("R9 R10 rx order", r, 32'h40 + 32'(i));
    end

    // R11 rx flush
    bus_wr(8'h68, 32'h5C);
    wait_idle();
    bus_rd(8'h64, r); check("R11 rx holds byte", {31'd0, r[0]}, 0);
    bus_wr(8'h60, 32'h0C7);
    bus_rd(8'h64, r); check("R11 rx flushed", {31'd0, r[0]}, 1);
    bus_rd(8'h60, r); check("R11 rx flush bit reads 0", r, 32'h087);

    // R8 and R12
    bus_wr(8'h70, 32'h5);
    check("R8 select output", 32'(ss_n), 32'h5);
    bus_wr(8'h40, 32'h05);
    bus_rd(8'h60, r); check("R12 wrong key ignored", r, 32'h087);
    bus_rd(8'h70, r); check("R12 wrong key keeps select", r, 32'h5);
    bus_wr(8'h40, 32'h0A);
    bus_rd(8'h60, r); check("R12 key resets control", r, 32'h180);
    bus_rd(8'h70, r); check("R12 key resets select", r, 32'hF);
    bus_rd(8'h64, r); check("R12 R2 key resets status", r, 32'h25);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule